// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block watches a matrix of up to six drive lines by five sense inputs (30 keys). While nothing is pressed it holds a static level on the drive lines. When any sense input goes high, it runs a timed scan that raises one drive line at a time and samples the sense inputs at the end of each line's slot. The matrix is scanned twice. A press is accepted only when both scans return the same non-empty result. The block then latches the result into a key data register and pulls an active-low read request low for the host.

The host acknowledges with a read-done strobe. The request then clears and the block scans again, and it keeps doing so until every key is released. Up to two of the lowest drive lines can be handed to other uses; their key bits then read as zero. In sleep mode the idle drive level follows a 2-bit pattern code. A press on a line that is high in that pattern wakes the scan, and a wake request is flagged while this happens.

Top module: `keymat_scanner`

## Requirements
- R1: With no line removed and sleep code 00, the idle drive output is 6'b111111. A scan begins only on a base tick in which some sense input is high.
- R2: A scan makes two passes. Each pass has six consecutive slots of 64 ticks, one for each drive line from line 1 (bit 0) to line 6 (bit 5). Exactly one drive line is high in each slot, and the sense inputs are sampled on the slot's last tick.
- R3: When both passes agree and hold at least one key, the request output goes low 800 ticks after the edge that began the scan.
- R4: If the passes disagree while some sense input is still high at the decision tick, a new scan starts at once, and a request can come no sooner than 1600 ticks after the first start. If the passes disagree and no key is held, no request is made.
- R5: A read-done strobe while the request is pending sets the request high on the next edge and starts a new scan. A key that is still held is reported again 800 ticks later.
- R6: While chip-enable is high the request output is high. It goes low again when chip-enable drops while the request is still pending.
- R7: The key on drive line r and sense input c (both counted from zero) is stored at key data bit 5*r+c.
- R8: Drop select 00 keeps all lines. 01 removes line 1 (bit 0). 10 or 11 removes lines 1 and 2 (bits 0 and 1). A removed line is always driven low and its five key bits read 0.
- R9: Sleep code bit patterns for the idle drive output are: 00 gives 6'b111111, 01 gives 6'b100000, 10 gives 6'b110000 and 11 gives 6'b111110. A press on a line that is high in the pattern starts a scan, and wake request is high while that scan or its pending request lasts. A press on a line held low starts nothing.
- R10: An active-low reset clears the key data to zero, stops any scan and holds the request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base clock enable; all scan timing counts these |
| senseIn | input | 5 | Sense inputs from the matrix columns |
| dropSel | input | 2 | Number of low drive lines removed from the matrix |
| sleepCode | input | 2 | Idle drive pattern code; 00 is normal mode |
| ceIn | input | 1 | Chip-enable; high forces the request high |
| readDone | input | 1 | Host strobe: key data has been read |
| driveOut | output | 6 | Drive lines to the matrix rows |
| reqN | output | 1 | Active-low key data read request |
| keyData | output | 30 | Confirmed key data |
| wakeReq | output | 1 | Sleep-mode press is being handled |

## Verification
Two functions can fall on the same tick: the pass-comparison decision and a change in which keys are held. The bench presses two keys, then releases the one on line 6 after the first pass has sampled it but before the second pass does. The decision tick then sees disagreeing passes while the other key still holds a sense line high. That case must rescan rather than go idle, and it is judged by the request arriving 1600 ticks after the press with only the held key reported. A second overlap is chip-enable going high in cycles when the request is pending. The request must read high during those cycles and return low after chip-enable drops, with the key data unchanged.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

  localparam int LINE_IDX_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } scanState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic                  scanDrive;
    logic                  sampleA;
    logic                  sampleB;
    logic                  captureKeys;
    logic [LINE_IDX_W-1:0] lineIdx;
  } dpStrobe_t;

endpackage

// File: rtl/keymat_ctrl.sv
module keymat_ctrl
  import keymat_pkg::*;
#(
  parameter int LINES         = 6,
  parameter int SLOT_TICKS    = 64,
  parameter int CONFIRM_TICKS = 800
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      anySense,
  input  logic      ceIn,
  input  logic      readDone,
  input  logic      sleepOn,
  input  logic      scansAgree,
  input  logic      scanNonZero,
  output dpStrobe_t strobes,
  output logic      reqN,
  output logic      wakeReq
);

  localparam int CNT_W  = $clog2(CONFIRM_TICKS + 1);
  localparam int SLOT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  scanState_e            state, nextState;
  logic [CNT_W-1:0]      cnt;
  logic [SLOT_W-1:0]     slotCnt;
  logic [LINE_IDX_W-1:0] lineIdx;
  logic                  passB;
  logic                  gap;
  logic                  restart;
  logic                  slotEnd, lineEnd, windowEnd;

  assign slotEnd   = (slotCnt == SLOT_W'(SLOT_TICKS - 1));
  assign lineEnd   = (lineIdx == LINE_IDX_W'(LINES - 1));
  assign windowEnd = (cnt == CNT_W'(CONFIRM_TICKS - 1));

  always_comb begin
    nextState = state;
    restart   = 1'b0;
    unique case (state)
      ST_IDLE: if (tick && anySense) begin
        nextState = ST_SCAN;
        restart   = 1'b1;
      end
      ST_SCAN: if (tick && windowEnd) begin
        if (scansAgree && scanNonZero) nextState = ST_HOLD;
        else if (!scansAgree && anySense) restart = 1'b1;
        else nextState = ST_IDLE;
      end
      ST_HOLD: if (readDone) begin
        nextState = ST_SCAN;
        restart   = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      slotCnt <= '0;
      lineIdx <= '0;
      passB   <= 1'b0;
      gap     <= 1'b0;
    end else begin
      state <= nextState;
      if (restart) begin
        cnt     <= '0;
        slotCnt <= '0;
        lineIdx <= '0;
        passB   <= 1'b0;
        gap     <= 1'b0;
      end else if (state == ST_SCAN && tick && !windowEnd) begin
        cnt <= cnt + 1'b1;
        if (!gap) begin
          if (slotEnd) begin
            slotCnt <= '0;
            if (lineEnd) begin
              lineIdx <= '0;
              if (passB) gap <= 1'b1;
              else passB <= 1'b1;
            end else begin
              lineIdx <= lineIdx + 1'b1;
            end
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strobes.scanDrive   = (state == ST_SCAN) && !gap;
    strobes.sampleA     = strobes.scanDrive && tick && slotEnd && !passB;
    strobes.sampleB     = strobes.scanDrive && tick && slotEnd && passB;
    strobes.captureKeys = (state == ST_SCAN) && tick && windowEnd && scansAgree && scanNonZero;
    strobes.lineIdx     = lineIdx;
  end

  assign reqN    = !((state == ST_HOLD) && !ceIn);
  assign wakeReq = sleepOn && ((state != ST_IDLE) || anySense);

  // R3: pending state is entered only at the end of the confirm window
  a_r3_confirm_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_HOLD) |-> $past(cnt) == CNT_W'(CONFIRM_TICKS - 1));

  // R4: a disagreeing decision with a key held restarts the window
  a_r4_rescan: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && tick && windowEnd && !scansAgree && anySense)
      |=> (state == ST_SCAN && cnt == '0));

  // R5: a read-done strobe in the pending state releases the request
  a_r5_read_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && readDone) |=> reqN);

endmodule

// File: rtl/keymat_dp.sv
module keymat_dp
  import keymat_pkg::*;
#(
  parameter int LINES  = 6,
  parameter int SENSES = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobes,
  input  logic [SENSES-1:0]        senseIn,
  input  logic [1:0]               dropSel,
  input  logic [1:0]               sleepCode,
  output logic [LINES-1:0]         driveOut,
  output logic [LINES*SENSES-1:0]  keyData,
  output logic                     scansAgree,
  output logic                     scanNonZero
);

  logic [LINES-1:0]              lineLive;
  logic [LINES-1:0]              idlePat;
  logic [LINES-1:0][SENSES-1:0]  scanA, scanB;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      lineLive[i] = 1'b1;
      if (i == 0 && dropSel != 2'b00) lineLive[i] = 1'b0;
      if (i == 1 && dropSel[1])       lineLive[i] = 1'b0;
      unique case (sleepCode)
        2'b00:   idlePat[i] = 1'b1;
        2'b01:   idlePat[i] = (i == LINES - 1);
        2'b10:   idlePat[i] = (i >= LINES - 2);
        default: idlePat[i] = (i >= 1);
      endcase
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_drive
    assign driveOut[g] = lineLive[g] &
      (strobes.scanDrive ? (strobes.lineIdx == LINE_IDX_W'(g)) : idlePat[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanA   <= '0;
      scanB   <= '0;
      keyData <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strobes.sampleA && strobes.lineIdx == LINE_IDX_W'(i))
          scanA[i] <= senseIn & {SENSES{lineLive[i]}};
        if (strobes.sampleB && strobes.lineIdx == LINE_IDX_W'(i))
          scanB[i] <= senseIn & {SENSES{lineLive[i]}};
      end
      if (strobes.captureKeys) keyData <= scanB;
    end
  end

  assign scansAgree  = (scanA == scanB);
  assign scanNonZero = |scanB;

  // R2: at most one drive line high during a scan slot
  a_r2_single_line: assert property (@(posedge clk) disable iff (!rstN)
    strobes.scanDrive |-> $onehot0(driveOut));

  // R10: key data changes only on a confirmed capture
  a_r10_keys_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureKeys |=> $stable(keyData));

  // R8: line 1 removed means its key bits stay zero after a capture
  a_r8_dropped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureKeys && dropSel != 2'b00 && $stable(dropSel))
      |=> keyData[SENSES-1:0] == '0);

endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner
  import keymat_pkg::*;
#(
  parameter int LINES         = 6,
  parameter int SENSES        = 5,
  parameter int SLOT_TICKS    = 64,
  parameter int CONFIRM_TICKS = 800
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic [SENSES-1:0]       senseIn,
  input  logic [1:0]              dropSel,
  input  logic [1:0]              sleepCode,
  input  logic                    ceIn,
  input  logic                    readDone,
  output logic [LINES-1:0]        driveOut,
  output logic                    reqN,
  output logic [LINES*SENSES-1:0] keyData,
  output logic                    wakeReq
);

  dpStrobe_t strobes;
  logic      scansAgree, scanNonZero;
  logic      anySense, sleepOn;

  assign anySense = |senseIn;
  assign sleepOn  = |sleepCode;

  keymat_ctrl #(
    .LINES(LINES), .SLOT_TICKS(SLOT_TICKS), .CONFIRM_TICKS(CONFIRM_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .anySense(anySense), .ceIn(ceIn),
    .readDone(readDone), .sleepOn(sleepOn), .scansAgree(scansAgree),
    .scanNonZero(scanNonZero), .strobes(strobes), .reqN(reqN), .wakeReq(wakeReq)
  );

  keymat_dp #(
    .LINES(LINES), .SENSES(SENSES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .senseIn(senseIn),
    .dropSel(dropSel), .sleepCode(sleepCode), .driveOut(driveOut),
    .keyData(keyData), .scansAgree(scansAgree), .scanNonZero(scanNonZero)
  );

  // R3: a request is only ever raised with some key recorded
  a_r3_req_has_keys: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqN) |-> keyData != '0);

endmodule

// File: tb/keymat_scanner_tb_top.sv
`timescale 1ns/1ps
module keymat_scanner_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic [4:0]  senseIn;
  logic [1:0]  dropSel = 2'b00;
  logic [1:0]  sleepCode = 2'b00;
  logic        ceIn = 1'b0;
  logic        readDone = 1'b0;
  logic [5:0]  driveOut;
  logic        reqN;
  logic [29:0] keyData;
  logic        wakeReq;
  logic [29:0] pressed = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  keymat_scanner dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .senseIn(senseIn), .dropSel(dropSel),
    .sleepCode(sleepCode), .ceIn(ceIn), .readDone(readDone), .driveOut(driveOut),
    .reqN(reqN), .keyData(keyData), .wakeReq(wakeReq)
  );

  // matrix model: a pressed key connects its row to its column
  always_comb begin
    senseIn = '0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 5; c++)
        if (pressed[r*5+c] && driveOut[r]) senseIn[c] = 1'b1;
  end

  // vector: drop[63:62] sleep[61:60] press[59:30] expected[29:0]
  localparam int NVEC = 9;
  localparam logic [63:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 30'h00000001, 30'h00000001},
    {2'd0, 2'd0, 30'h20000080, 30'h20000080},
    {2'd1, 2'd0, 30'h00001004, 30'h00001000},
    {2'd2, 2'd0, 30'h00100110, 30'h00100000},
    {2'd0, 2'd1, 30'h08000000, 30'h08000000},
    {2'd0, 2'd1, 30'h00000008, 30'h00000000},
    {2'd0, 2'd3, 30'h00000040, 30'h00000040},
    {2'd0, 2'd2, 30'h00400000, 30'h00400000},
    {2'd3, 2'd0, 30'h00004000, 30'h00004000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] idleExp(input logic [1:0] d, input logic [1:0] s);
    logic [5:0] p;
    case (s)
      2'd0: p = 6'b111111;
      2'd1: p = 6'b100000;
      2'd2: p = 6'b110000;
      default: p = 6'b111110;
    endcase
    if (d != 2'd0) p[0] = 1'b0;
    if (d[1])      p[1] = 1'b0;
    return p;
  endfunction

  // counts posedges until reqN is seen low at a negedge; -1 on timeout
  task automatic waitReq(input int maxN, output int n);
    n = 0;
    while (n < maxN) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (!reqN) return;
    end
    n = -1;
  endtask

  task automatic pulseRead();
    @(negedge clk);
    readDone = 1'b1;
    @(negedge clk);
    readDone = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(keyData == '0, "R10 reset keys", 32'(keyData), 0);
    chk(reqN == 1'b1, "R10 reset request", 32'(reqN), 1);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk(driveOut == 6'b111111, "R1 idle drive", 32'(driveOut), 32'h3f);

    // R2 slot order, R3 timing, R7 position
    pressed = 30'h1 << 17;
    repeat (33) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      chk(driveOut == (6'b1 << (k % 6)), "R2 slot line", 32'(driveOut), 32'(6'b1 << (k % 6)));
      if (k < 11) begin
        repeat (64) @(posedge clk);
        @(negedge clk);
      end
    end
    chk(reqN == 1'b1, "R3 request before window", 32'(reqN), 1);
    waitReq(100, n);
    chk(n == 64, "R3 request at 800 ticks", 32'(n), 64);
    chk(keyData == (30'h1 << 17), "R7 key bit 5r+c", 32'(keyData), 32'h20000);

    // R6 chip-enable forces request high
    ceIn = 1'b1;
    @(negedge clk);
    chk(reqN == 1'b1, "R6 ce high", 32'(reqN), 1);
    repeat (5) @(negedge clk);
    chk(reqN == 1'b1, "R6 ce held", 32'(reqN), 1);
    ceIn = 1'b0;
    @(negedge clk);
    chk(reqN == 1'b0, "R6 ce released", 32'(reqN), 0);
    chk(keyData == (30'h1 << 17), "R6 keys kept", 32'(keyData), 32'h20000);

    // R5 read-done releases request and rescans a held key
    readDone = 1'b1;
    @(negedge clk);
    readDone = 1'b0;
    chk(reqN == 1'b1, "R5 request cleared", 32'(reqN), 1);
    waitReq(1000, n);
    chk(n == 800, "R5 held key reported again", 32'(n), 800);

    // R10 reset while pending
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(keyData == '0, "R10 keys cleared", 32'(keyData), 0);
    chk(reqN == 1'b1, "R10 request high", 32'(reqN), 1);
    pressed = '0;
    @(negedge clk);
    rstN = 1'b1;
    waitReq(900, n);
    chk(n == -1, "R10 no scan after reset", 32'(n), 32'hffffffff);

    // R4 disagreeing passes with a key held -> rescan, 1600 ticks
    pressed = (30'h1 << 0) | (30'h1 << 29);
    repeat (501) @(posedge clk);
    @(negedge clk);
    pressed = 30'h1;
    waitReq(1500, n);
    chk(n + 501 == 1601, "R4 rescan timing", 32'(n + 501), 1601);
    chk(keyData == 30'h1, "R4 rescan keys", 32'(keyData), 1);
    pulseRead();
    pressed = '0;
    repeat (850) @(negedge clk);

    // R4 short press never reported
    pressed = 30'h1 << 10;
    repeat (401) @(posedge clk);
    @(negedge clk);
    pressed = '0;
    waitReq(1200, n);
    chk(n == -1, "R4 short press ignored", 32'(n), 32'hffffffff);
    chk(keyData == 30'h1, "R4 keys unchanged", 32'(keyData), 1);

    // table-driven: modes, patterns, key positions
    for (int v = 0; v < NVEC; v++) begin
      logic [29:0] exp;
      dropSel   = VEC[v][63:62];
      sleepCode = VEC[v][61:60];
      exp       = VEC[v][29:0];
      @(negedge clk);
      chk(driveOut == idleExp(dropSel, sleepCode), "R1 R8 R9 idle pattern",
          32'(driveOut), 32'(idleExp(dropSel, sleepCode)));
      pressed = VEC[v][59:30];
      waitReq(1000, n);
      if (exp == '0) begin
        chk(n == -1, "R9 low line no scan", 32'(n), 32'hffffffff);
        chk(wakeReq == 1'b0, "R9 no wake", 32'(wakeReq), 0);
      end else begin
        chk(n == 801, "R3 confirm delay", 32'(n), 801);
        chk(keyData == exp, "R7 R8 R9 key data", 32'(keyData), 32'(exp));
        if (sleepCode != 2'd0)
          chk(wakeReq == 1'b1, "R9 wake request", 32'(wakeReq), 1);
      end
      @(negedge clk);
      readDone = 1'b1;
      pressed  = '0;
      @(negedge clk);
      readDone = 1'b0;
      repeat (820) @(negedge clk);
      chk(reqN == 1'b1, "R5 released keys no request", 32'(reqN), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule